// File: doc/BRIEF.md
# Prioritized Timer Interrupt Arbiter

This block gathers the two compare-match events of each of six timer channels. That makes twelve interrupt sources, and the block reduces them to one interrupt request toward a CPU. Each event is held in a cause flag until software clears it. A per-source enable bit masks the flag. A per-channel 3-bit priority level, shared by both sources of the channel, ranks the unmasked sources. A fixed rule settles ties. The winner is presented as a registered valid, source index and level.

A final gate forwards the winner to the CPU. It does so only when the CPU's global interrupt enable is set and the winner's level is strictly above the CPU's current level. Software reaches the flags, enables and levels through a small byte-wide register port. Reads on that port are combinational and writes take effect at the clock edge.

Top module: `tmr_irq_arbiter`

## Requirements
- R1: After reset, every flag, enable bit and priority level reads 0, `req_valid` is 0 and `cpu_irq` is 0.
- R2: A 1 on `match_a[c]` or `match_b[c]` at a clock edge sets the matching cause flag, whatever the value of its enable bit.
- R3: Writing a flag byte clears each flag whose bit in the written data is 1 and leaves flags whose bit is 0 unchanged. A match in the same cycle as a clear of the same flag leaves the flag set.
- R4: A source is pending only when its flag is 1, its enable bit is 1 and its channel level is nonzero. When nothing is pending, `req_valid`, `req_src` and `req_level` are all 0.
- R5: Among pending sources, the one whose channel has the highest level is selected.
- R6: Among pending sources of equal level, the lower-numbered channel wins.
- R7: Within one channel, compare B wins over compare A. `req_src` is 2*channel, plus 1 for compare B.
- R8: `req_valid`, `req_src` and `req_level` are registered. They reflect the flag, enable and level state one clock edge after that state changes, and `req_level` is the winning channel's level.
- R9: `cpu_irq` is 1 exactly when `req_valid` is 1, `cpu_ie` is 1 and `req_level` is strictly greater than `cpu_level`.
- R10: Register map. Flag bytes are at addresses 0,1,2, enable bytes at 4,5,6 and priority bytes at 8,9,10, and byte k serves channels 2k and 2k+1. In flag and enable bytes, bit 3 is channel 2k compare A, bit 2 is channel 2k compare B, bit 7 is channel 2k+1 compare A and bit 6 is channel 2k+1 compare B. In priority bytes, bits [2:0] hold channel 2k's level and bits [6:4] hold channel 2k+1's level. Other bits read 0.
- R11: Reads of unmapped addresses return 0, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| match_a | input | 6 | Compare-match A event per channel |
| match_b | input | 6 | Compare-match B event per channel |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_level | input | 3 | CPU current interrupt level |
| req_valid | output | 1 | A source is pending |
| req_src | output | 4 | Winning source index |
| req_level | output | 3 | Winning level |
| cpu_irq | output | 1 | Interrupt request accepted toward the CPU |

## Verification
Directed cases put two sources against each other so that only one rule can decide the winner:
- a higher level against a lower channel number, which isolates level ranking;
- equal levels, which isolates the channel-number tie-break;
- both causes of one channel, which isolates B over A;
- masked flags and level-0 channels, which must never be selected.

The CPU gate is driven with `cpu_level` below, equal to and above the winner's level, and with `cpu_ie` low, which separates the strict from the non-strict comparison. A clear written in the same cycle as a match shows whether the set takes precedence. Long random runs then mix sparse match events, register writes to mapped and unmapped addresses and changing CPU state, and compare every cycle against a bench model of the flags and the ranking.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned DATA_W = 8;
  // byte address bases, each group holds consecutive bytes, one per channel pair
  localparam logic [ADDR_W-1:0] FLAG_BASE = 4'h0;
  localparam logic [ADDR_W-1:0] ENA_BASE  = 4'h4;
  localparam logic [ADDR_W-1:0] LVL_BASE  = 4'h8;
  // bit positions inside flag/enable bytes
  localparam int unsigned BIT_A_EVEN = 3;
  localparam int unsigned BIT_B_EVEN = 2;
  localparam int unsigned BIT_A_ODD  = 7;
  localparam int unsigned BIT_B_ODD  = 6;
  // low bit of the level field inside a priority byte
  localparam int unsigned LVL_LO_EVEN = 0;
  localparam int unsigned LVL_LO_ODD  = 4;
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       match_a,
  input  logic [NUM_CH-1:0]       match_b,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic [NUM_CH-1:0]       flag_a,
  output logic [NUM_CH-1:0]       flag_b,
  output logic [NUM_CH-1:0]       en_a,
  output logic [NUM_CH-1:0]       en_b,
  output logic [NUM_CH*LVL_W-1:0] lvl
);

  logic [NUM_CH-1:0]       flag_a_nx, flag_b_nx;
  logic [NUM_CH-1:0]       en_a_nx, en_b_nx;
  logic [NUM_CH-1:0]       en_we, lvl_we;
  logic [NUM_CH*LVL_W-1:0] lvl_nx;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam bit          ODD  = (c % 2) == 1;
    localparam int unsigned BA   = ODD ? BIT_A_ODD : BIT_A_EVEN;
    localparam int unsigned BB   = ODD ? BIT_B_ODD : BIT_B_EVEN;
    localparam int unsigned LL   = ODD ? LVL_LO_ODD : LVL_LO_EVEN;
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_BASE + c / 2);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_BASE + c / 2);
    localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(LVL_BASE + c / 2);

    logic clr_a, clr_b;

    always_comb begin
      clr_a        = reg_wr && (reg_addr == A_FLAG) && reg_wdata[BA];
      clr_b        = reg_wr && (reg_addr == A_FLAG) && reg_wdata[BB];
      // a match arriving with a clear keeps the flag set
      flag_a_nx[c] = (flag_a[c] & ~clr_a) | match_a[c];
      flag_b_nx[c] = (flag_b[c] & ~clr_b) | match_b[c];
      en_we[c]     = reg_wr && (reg_addr == A_ENA);
      en_a_nx[c]   = reg_wdata[BA];
      en_b_nx[c]   = reg_wdata[BB];
      lvl_we[c]    = reg_wr && (reg_addr == A_LVL);
      lvl_nx[c*LVL_W +: LVL_W] = reg_wdata[LL +: LVL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_a[c] <= 1'b0;
        flag_b[c] <= 1'b0;
      end else begin
        flag_a[c] <= flag_a_nx[c];
        flag_b[c] <= flag_b_nx[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_a[c] <= 1'b0;
        en_b[c] <= 1'b0;
      end else if (en_we[c]) begin
        en_a[c] <= en_a_nx[c];
        en_b[c] <= en_b_nx[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl[c*LVL_W +: LVL_W] <= '0;
      end else if (lvl_we[c]) begin
        lvl[c*LVL_W +: LVL_W] <= lvl_nx[c*LVL_W +: LVL_W];
      end
    end
  end

  // combinational read mux
  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(FLAG_BASE + c / 2)) begin
        reg_rdata[(c % 2) ? BIT_A_ODD : BIT_A_EVEN] = flag_a[c];
        reg_rdata[(c % 2) ? BIT_B_ODD : BIT_B_EVEN] = flag_b[c];
      end
      if (reg_addr == ADDR_W'(ENA_BASE + c / 2)) begin
        reg_rdata[(c % 2) ? BIT_A_ODD : BIT_A_EVEN] = en_a[c];
        reg_rdata[(c % 2) ? BIT_B_ODD : BIT_B_EVEN] = en_b[c];
      end
      if (reg_addr == ADDR_W'(LVL_BASE + c / 2)) begin
        reg_rdata[((c % 2) ? LVL_LO_ODD : LVL_LO_EVEN) +: LVL_W] = lvl[c*LVL_W +: LVL_W];
      end
    end
  end

endmodule

// File: rtl/tmr_irq_pick.sv
module tmr_irq_pick
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned SRC_W  = $clog2(2 * NUM_CH)
) (
  input  logic [NUM_CH-1:0]       flag_a,
  input  logic [NUM_CH-1:0]       flag_b,
  input  logic [NUM_CH-1:0]       en_a,
  input  logic [NUM_CH-1:0]       en_b,
  input  logic [NUM_CH*LVL_W-1:0] lvl,
  output logic                    win_valid,
  output logic [SRC_W-1:0]        win_src,
  output logic [LVL_W-1:0]        win_lvl
);

  logic [NUM_CH-1:0] pend_a, pend_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pend_a[c] = flag_a[c] & en_a[c] & (lvl[c*LVL_W +: LVL_W] != '0);
    assign pend_b[c] = flag_b[c] & en_b[c] & (lvl[c*LVL_W +: LVL_W] != '0);
  end

  // scan order: channel ascending, B before A; only a strictly higher level
  // displaces an earlier candidate, which yields both tie-break rules
  always_comb begin
    logic             p;
    logic [LVL_W-1:0] l;
    win_valid = 1'b0;
    win_src   = '0;
    win_lvl   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      l = lvl[c*LVL_W +: LVL_W];
      for (int s = 1; s >= 0; s--) begin
        p = (s == 1) ? pend_b[c] : pend_a[c];
        if (p && (!win_valid || (l > win_lvl))) begin
          win_valid = 1'b1;
          win_lvl   = l;
          win_src   = SRC_W'(2 * c + s);
        end
      end
    end
  end

endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate
  import tmr_irq_pkg::*;
(
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             cpu_ie,
  input  logic [LVL_W-1:0] cpu_level,
  output logic             cpu_irq
);

  always_comb begin
    cpu_irq = req_valid && cpu_ie && (req_level > cpu_level);
  end

endmodule

// File: rtl/tmr_irq_arbiter.sv
module tmr_irq_arbiter
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned SRC_W = $clog2(2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] match_a,
  input  logic [NUM_CH-1:0] match_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_ie,
  input  logic [LVL_W-1:0]  cpu_level,
  output logic              req_valid,
  output logic [SRC_W-1:0]  req_src,
  output logic [LVL_W-1:0]  req_level,
  output logic              cpu_irq
);

  logic [1:0]              rst_pipe;
  logic                    rst_q;
  logic [NUM_CH-1:0]       flag_a, flag_b, en_a, en_b;
  logic [NUM_CH*LVL_W-1:0] lvl;
  logic                    win_valid;
  logic [SRC_W-1:0]        win_src;
  logic [LVL_W-1:0]        win_lvl;
  logic                    req_valid_nx;
  logic [SRC_W-1:0]        req_src_nx;
  logic [LVL_W-1:0]        req_level_nx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  tmr_irq_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .match_a   (match_a),
    .match_b   (match_b),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .en_a      (en_a),
    .en_b      (en_b),
    .lvl       (lvl)
  );

  tmr_irq_pick #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) pick_i (
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .en_a      (en_a),
    .en_b      (en_b),
    .lvl       (lvl),
    .win_valid (win_valid),
    .win_src   (win_src),
    .win_lvl   (win_lvl)
  );

  always_comb begin
    req_valid_nx = win_valid;
    req_src_nx   = win_src;
    req_level_nx = win_lvl;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      req_valid <= 1'b0;
      req_src   <= '0;
      req_level <= '0;
    end else begin
      req_valid <= req_valid_nx;
      req_src   <= req_src_nx;
      req_level <= req_level_nx;
    end
  end

  tmr_irq_gate gate_i (
    .req_valid (req_valid),
    .req_level (req_level),
    .cpu_ie    (cpu_ie),
    .cpu_level (cpu_level),
    .cpu_irq   (cpu_irq)
  );

endmodule

// File: rtl/tmr_irq_arbiter_chk.sv
module tmr_irq_arbiter_chk
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned SRC_W  = $clog2(2 * NUM_CH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       match_a,
  input logic [NUM_CH-1:0]       match_b,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic                    reg_wr,
  input logic [DATA_W-1:0]       reg_wdata,
  input logic [NUM_CH-1:0]       flag_a,
  input logic [NUM_CH-1:0]       flag_b,
  input logic [NUM_CH-1:0]       en_a,
  input logic [NUM_CH-1:0]       en_b,
  input logic [NUM_CH*LVL_W-1:0] lvl,
  input logic                    req_valid,
  input logic [SRC_W-1:0]        req_src,
  input logic [LVL_W-1:0]        req_level,
  input logic                    cpu_ie,
  input logic [LVL_W-1:0]        cpu_level,
  input logic                    cpu_irq
);

  logic any_pend;
  always_comb begin
    any_pend = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if ((flag_a[c] & en_a[c]) | (flag_b[c] & en_b[c]))
        if (lvl[c*LVL_W +: LVL_W] != '0) any_pend = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned BA = (c % 2) ? BIT_A_ODD : BIT_A_EVEN;
    localparam int unsigned BB = (c % 2) ? BIT_B_ODD : BIT_B_EVEN;
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_BASE + c / 2);

    a_r2_set_a: assert property (@(posedge clk) disable iff (!rst_n)
      match_a[c] |=> flag_a[c]);
    a_r2_set_b: assert property (@(posedge clk) disable iff (!rst_n)
      match_b[c] |=> flag_b[c]);
    a_r3_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_FLAG && reg_wdata[BA] && !match_a[c]) |=> !flag_a[c]);
    a_r3_clear_b: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_FLAG && reg_wdata[BB] && !match_b[c]) |=> !flag_b[c]);
  end

  a_r4_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(any_pend));
  a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !req_valid);
  a_r4_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_level != '0);
  a_r7_src_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_src < SRC_W'(2 * NUM_CH));
  a_r9_ie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ie |-> !cpu_irq);
  a_r9_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (req_level <= cpu_level) |-> !cpu_irq);

endmodule

bind tmr_irq_arbiter tmr_irq_arbiter_chk #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q),
  .match_a   (match_a),
  .match_b   (match_b),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .flag_a    (flag_a),
  .flag_b    (flag_b),
  .en_a      (en_a),
  .en_b      (en_b),
  .lvl       (lvl),
  .req_valid (req_valid),
  .req_src   (req_src),
  .req_level (req_level),
  .cpu_ie    (cpu_ie),
  .cpu_level (cpu_level),
  .cpu_irq   (cpu_irq)
);

// File: tb/tmr_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_arbiter_tb_top;

  localparam int NCH = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] match_a, match_b;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       cpu_ie;
  logic [2:0] cpu_level;
  logic       req_valid;
  logic [3:0] req_src;
  logic [2:0] req_level;
  logic       cpu_irq;

  int n_chk  = 0;
  int n_fail = 0;

  bit mf_a[NCH], mf_b[NCH], me_a[NCH], me_b[NCH];
  int ml[NCH];

  always #2.5 clk = ~clk;

  tmr_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_ie(cpu_ie), .cpu_level(cpu_level),
    .req_valid(req_valid), .req_src(req_src), .req_level(req_level),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pos_a(int c); return (c % 2) ? 7 : 3; endfunction
  function automatic int pos_b(int c); return (c % 2) ? 6 : 2; endfunction
  function automatic int pos_l(int c); return (c % 2) ? 4 : 0; endfunction

  function automatic logic [7:0] exp_byte(input int a);
    logic [7:0] b = 8'h00;
    for (int c = 0; c < NCH; c++) begin
      if (a == c / 2)     begin b[pos_a(c)] = mf_a[c]; b[pos_b(c)] = mf_b[c]; end
      if (a == 4 + c / 2) begin b[pos_a(c)] = me_a[c]; b[pos_b(c)] = me_b[c]; end
      if (a == 8 + c / 2) b[pos_l(c) +: 3] = 3'(ml[c]);
    end
    return b;
  endfunction

  // winner from the ranking rules: highest level, then lowest channel, then B over A
  function automatic void model_arb(output bit v, output int src, output int lv);
    v = 0; src = 0; lv = 0;
    for (int l = 7; l >= 1 && !v; l--)
      for (int c = 0; c < NCH && !v; c++)
        if (ml[c] == l) begin
          if (mf_b[c] && me_b[c])      begin v = 1; src = 2 * c + 1; lv = l; end
          else if (mf_a[c] && me_a[c]) begin v = 1; src = 2 * c;     lv = l; end
        end
  endfunction

  function automatic void model_upd(input logic [5:0] ma, input logic [5:0] mb,
                                    input bit wr, input int a, input logic [7:0] d);
    for (int c = 0; c < NCH; c++) begin
      bit ca = wr && (a == c / 2) && d[pos_a(c)];
      bit cb = wr && (a == c / 2) && d[pos_b(c)];
      mf_a[c] = (mf_a[c] && !ca) || ma[c];
      mf_b[c] = (mf_b[c] && !cb) || mb[c];
      if (wr && a == 4 + c / 2) begin me_a[c] = d[pos_a(c)]; me_b[c] = d[pos_b(c)]; end
      if (wr && a == 8 + c / 2) ml[c] = int'(d[pos_l(c) +: 3]);
    end
  endfunction

  // one clock: drive at negedge, check registered outputs at the next negedge
  task automatic cyc(input string tag, input logic [5:0] ma, input logic [5:0] mb,
                     input bit wr, input int a, input logic [7:0] d);
    bit ev; int es, el;
    logic [7:0] exp_req;
    bit exp_irq;
    match_a = ma; match_b = mb; reg_wr = wr; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    model_arb(ev, es, el);
    model_upd(ma, mb, wr, a, d);
    @(negedge clk);
    match_a = '0; match_b = '0; reg_wr = 1'b0;
    exp_req = ev ? {1'b1, 4'(es), 3'(el)} : 8'h00;
    chk({req_valid, req_src, req_level} == exp_req, {tag, " req"},
        int'({req_valid, req_src, req_level}), int'(exp_req));
    exp_irq = ev && cpu_ie && (el > int'(cpu_level));
    chk(cpu_irq == exp_irq, "R9 irq", int'(cpu_irq), int'(exp_irq));
  endtask

  task automatic idle(input string tag);
    cyc(tag, 6'h00, 6'h00, 1'b0, 0, 8'h00);
  endtask

  task automatic wr(input string tag, input int a, input logic [7:0] d);
    cyc(tag, 6'h00, 6'h00, 1'b1, a, d);
  endtask

  task automatic rd(input string tag, input int a);
    logic [7:0] e;
    reg_addr = 4'(a);
    #1;
    e = exp_byte(a);
    chk(reg_rdata == e, tag, int'(reg_rdata), int'(e));
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      mf_a[c] = 0; mf_b[c] = 0; me_a[c] = 0; me_b[c] = 0; ml[c] = 0;
    end
    rst_n = 1'b0; match_a = '0; match_b = '0; reg_addr = '0; reg_wr = 1'b0;
    reg_wdata = '0; cpu_ie = 1'b0; cpu_level = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
    chk(cpu_irq == 1'b0, "R1 cpu_irq", int'(cpu_irq), 0);
    for (int a = 0; a < 11; a++) if (a % 4 != 3) rd("R1 reg", a);

    // R2 flag latches while masked
    cyc("R2", 6'b001000, 6'h00, 1'b0, 0, 8'h00);
    rd("R2 flag ch3A", 1);
    cyc("R2", 6'h00, 6'b000100, 1'b0, 0, 8'h00);
    rd("R2 flag ch2B", 1);
    idle("R4 masked");

    // R3 clear rules
    wr("R3 zero write", 1, 8'h00);
    rd("R3 hold", 1);
    wr("R3 clear", 1, 8'h84);
    rd("R3 cleared", 1);
    cyc("R3 set wins", 6'b001000, 6'h00, 1'b1, 1, 8'h80);
    rd("R3 set wins", 1);

    // R4 level 0 never pending, then nonzero level becomes visible (R8 latency)
    wr("R4 enable", 5, 8'h80);
    idle("R4 level0");
    wr("R4 set level", 9, 8'h50);
    idle("R8 latency");
    rd("R10 lvl byte", 9);

    // R5 higher level beats lower channel
    wr("R5", 8, 8'h02);
    wr("R5", 4, 8'h04);
    cyc("R5", 6'h00, 6'b000001, 1'b0, 0, 8'h00);
    idle("R5 ch3 lvl5 wins");
    wr("R5", 9, 8'h10);
    idle("R5 ch0 lvl2 wins");

    // R6 equal levels: lower channel
    wr("R6", 8, 8'h01);
    idle("R6 tie");

    // R7 B over A inside a channel
    wr("R7", 4, 8'h0C);
    cyc("R7", 6'b000001, 6'h00, 1'b0, 0, 8'h00);
    idle("R7 B wins");
    wr("R7 clear B", 0, 8'h04);
    idle("R7 A left");

    // R9 CPU gate, strict comparison
    cpu_ie = 1'b1; cpu_level = 3'd0; idle("R9 below");
    cpu_level = 3'd1; idle("R9 equal");
    cpu_level = 3'd2; idle("R9 above");
    cpu_ie = 1'b0; cpu_level = 3'd0; idle("R9 ie off");

    // R11 unmapped accesses
    wr("R11", 3, 8'hFF);
    wr("R11", 15, 8'hFF);
    wr("R11", 12, 8'hFF);
    for (int a = 0; a < 16; a++) rd("R11 read", a);

    // random phase
    void'($urandom(32'd51177));
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] ma, mb;
      bit w;
      int a;
      logic [7:0] d;
      ma = 6'($urandom) & 6'($urandom) & 6'($urandom);
      mb = 6'($urandom) & 6'($urandom) & 6'($urandom);
      w = ($urandom % 4) == 0;
      case ($urandom % 4)
        0: a = $urandom % 3;
        1: a = 4 + $urandom % 3;
        2: a = 8 + $urandom % 3;
        default: a = $urandom % 16;
      endcase
      d = 8'($urandom);
      cpu_ie = 1'($urandom);
      cpu_level = 3'($urandom);
      cyc("R8 random", ma, mb, w, a, d);
      if (i % 8 == 0) rd("R10 random read", $urandom % 16);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule